// File: doc/BRIEF.md
# Dual-Mode Survivor Traceback Unit

This unit walks backwards through a trellis, one stage per clock, using decision bits that an add-compare-select array has already stored. Starting from a given state at a given stage, it reads that stage's decision word, picks out the bit belonging to the current state, and works out the state the path came from. The same predecessor rule, scaled by the constraint length K (3 to 9, so up to 256 states), covers every code.

For each step it emits one decoded bit, newest stage first. In non-recursive (Viterbi) mode the bit is whether the current state lies in the upper half of the state space. In recursive-code (Turbo) mode the bit comes from a 512-entry, one-bit table that software loads before decoding, indexed by twice the state plus the decision bit. Putting the bits back into time order, and updating soft reliabilities, are handled elsewhere.

Top module: `trellis_backtrace`

## Requirements
- R1: While `rst_n` is low, `busy`, `done` and `bit_valid` are 0, and every table entry is cleared to 0.
- R2: When a step is taken from state C with decision bit d, and C >= 2^(K-2), the next state is 2C+d-2^(K-1). In Viterbi mode (`mode`=0) the emitted bit is 1.
- R3: When a step is taken from state C with decision bit d, and C < 2^(K-2), the next state is 2C+d. In Viterbi mode the emitted bit is 0.
- R4: In Turbo mode (`mode`=1) the emitted bit is the table entry at index 2C+d.
- R5: A table write (`tbl_we`=1) stores `tbl_wdata` at `tbl_addr` on the clock edge. A step taken on that same edge reads the entry's old value.
- R6: The unit takes one step per clock while `busy`. Each step produces one `bit_valid` pulse one edge later. `mem_addr` starts at `end_stage` and decreases by one per step. The decision bit is `mem_rdata[C]`.
- R7: After exactly `depth` steps, `busy` falls and `done` pulses for one cycle, in the same cycle as the last `bit_valid`. A start with `depth`=0 gives a `done` pulse on the next cycle and emits no bits.
- R8: A `start` pulse while `busy` is 1 is ignored, and the running traceback continues unchanged.
- R9: Only the low K-1 bits of `start_state` are loaded. A `k_len` below 3 is treated as 3, and a `k_len` above 9 as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_len | input | 4 | Constraint length K |
| mode | input | 1 | 0 = Viterbi bit, 1 = table (Turbo) bit |
| start | input | 1 | Begin a traceback |
| start_state | input | 8 | State the traceback begins from |
| depth | input | 10 | Number of steps to take |
| end_stage | input | 10 | Stage index of the first decision word read |
| tbl_we | input | 1 | Decision table write enable |
| tbl_addr | input | 9 | Decision table write index |
| tbl_wdata | input | 1 | Decision table write value |
| mem_rdata | input | 256 | Decision word for the addressed stage (combinational read) |
| mem_addr | output | 10 | Stage index being read |
| cur_state | output | 8 | Current trellis state |
| bit_out | output | 1 | Decoded bit |
| bit_valid | output | 1 | `bit_out` holds a new bit |
| busy | output | 1 | Traceback in progress |
| done | output | 1 | One-cycle pulse at the end of a traceback |

## Verification
Two functions can act on the same table entry in one cycle: a table write, and the Turbo-mode lookup made by a traceback step. The bench provokes this by running a Turbo traceback while, on every cycle, it writes the inverse of the entry that its reference model says the step is about to read. The emitted bit must then equal the old entry, and a later lookup of that index must see the new value. A second overlap, a `start` arriving during a run, is judged by checking that the running traceback's bit count, state and stage address do not change.

// File: rtl/trellis_backtrace.sv
module trellis_backtrace #(
  parameter int MAXK = 9,
  parameter int KW   = 4,
  parameter int DW   = 10,
  parameter int AW   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [KW-1:0]         k_len,
  input  logic                  mode,
  input  logic                  start,
  input  logic [MAXK-2:0]       start_state,
  input  logic [DW-1:0]         depth,
  input  logic [AW-1:0]         end_stage,
  input  logic                  tbl_we,
  input  logic [MAXK-1:0]       tbl_addr,
  input  logic                  tbl_wdata,
  input  logic [(1<<(MAXK-1))-1:0] mem_rdata,
  output logic [AW-1:0]         mem_addr,
  output logic [MAXK-2:0]       cur_state,
  output logic                  bit_out,
  output logic                  bit_valid,
  output logic                  busy,
  output logic                  done
);
  localparam int SW = MAXK - 1;
  localparam int TW = SW + 1;
  localparam int TS = 1 << TW;

  logic [KW-1:0] kc;
  logic [TW-1:0] full_w, idx, prev_w;
  logic [SW-1:0] half, mask, prev;
  logic          decbit, upper;
  logic [DW-1:0] cnt;
  logic [TS-1:0] tbl;

  assign kc     = (k_len < KW'(3)) ? KW'(3) : (k_len > KW'(MAXK)) ? KW'(MAXK) : k_len;
  assign full_w = TW'(1) << (kc - KW'(1));
  assign half   = SW'(full_w >> 1);
  assign mask   = SW'(full_w - TW'(1));
  assign decbit = mem_rdata[cur_state];
  assign idx    = {cur_state, decbit};
  assign upper  = cur_state >= half;
  assign prev_w = upper ? idx - full_w : idx;
  assign prev   = SW'(prev_w) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl <= '0;
    else if (tbl_we) tbl[tbl_addr] <= tbl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
      cur_state <= '0;
      mem_addr  <= '0;
      cnt       <= '0;
    end else begin
      bit_valid <= 1'b0;
      done      <= 1'b0;
      if (busy) begin
        bit_valid <= 1'b1;
        bit_out   <= mode ? tbl[idx] : upper;
        cur_state <= prev;
        mem_addr  <= mem_addr - AW'(1);
        cnt       <= cnt - DW'(1);
        if (cnt == DW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        if (depth == '0) begin
          done <= 1'b1;
        end else begin
          busy      <= 1'b1;
          cur_state <= start_state & mask;
          mem_addr  <= end_stage;
          cnt       <= depth;
        end
      end
    end
  end
endmodule

// File: rtl/trellis_backtrace_chk.sv
module trellis_backtrace_chk #(
  parameter int MAXK = 9,
  parameter int KW   = 4,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [KW-1:0]   k_len,
  input logic            mode,
  input logic [MAXK-2:0] cur_state,
  input logic [AW-1:0]   mem_addr,
  input logic            bit_out,
  input logic            bit_valid,
  input logic            busy,
  input logic            done
);
  localparam int SW = MAXK - 1;
  logic [KW-1:0] kk;
  logic [SW:0]   fw;
  logic [SW-1:0] hf, msk;
  assign kk  = (k_len < KW'(3)) ? KW'(3) : (k_len > KW'(MAXK)) ? KW'(MAXK) : k_len;
  assign fw  = (SW+1)'(1) << (kk - KW'(1));
  assign hf  = SW'(fw >> 1);
  assign msk = SW'(fw - (SW+1)'(1));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!busy && !done && !bit_valid));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> mem_addr == $past(mem_addr) - AW'(1));
  // R2
  vit_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(mode)) |-> (bit_valid && bit_out == ($past(cur_state) >= $past(hf))));
  // R9
  state_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ((cur_state & ~$past(msk)) == '0));
endmodule

bind trellis_backtrace trellis_backtrace_chk #(.MAXK(MAXK), .KW(KW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .k_len(k_len), .mode(mode), .cur_state(cur_state),
  .mem_addr(mem_addr), .bit_out(bit_out), .bit_valid(bit_valid), .busy(busy), .done(done)
);

// File: tb/sim_trellis_backtrace.sv
module sim_trellis_backtrace;
  localparam int PER = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] k_len = 4'd3;
  logic mode = 1'b0, start = 1'b0, tbl_we = 1'b0, tbl_wdata = 1'b0;
  logic [7:0] start_state = '0;
  logic [9:0] depth = '0, end_stage = '0;
  logic [8:0] tbl_addr = '0;
  logic [255:0] mem_rdata;
  logic [9:0] mem_addr;
  logic [7:0] cur_state;
  logic bit_out, bit_valid, busy, done;

  logic [255:0] dmem [64];
  assign mem_rdata = dmem[mem_addr[5:0]];

  trellis_backtrace u0 (.*);

  always #(PER/2) clk = ~clk;

  int nchk = 0, nbad = 0, cyc = 0, nbits = 0, ndone = 0;
  bit mtbl [512];
  bit m_busy, m_done, m_valid, m_bit;
  int m_state, m_stage, m_cnt;
  string m_tag = "R2";

  function automatic int kcl(input int k);
    return k < 3 ? 3 : (k > 9 ? 9 : k);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_valid = 0; m_bit = 0; m_state = 0; m_stage = 0; m_cnt = 0;
      foreach (mtbl[i]) mtbl[i] = 0;
    end else begin
      int kc, full, half, c, d, ix;
      kc = kcl(k_len); full = 1 << (kc - 1); half = full >> 1;
      m_valid = 0; m_done = 0;
      if (m_busy) begin
        c = m_state; d = dmem[m_stage & 63][c]; ix = 2 * c + d;
        m_bit = mode ? mtbl[ix] : (c >= half);
        m_tag = mode ? "R4" : (c >= half ? "R2" : "R3");
        m_state = (c >= half) ? ix - full : ix;
        m_valid = 1; m_stage = (m_stage - 1) & 1023; m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        if (depth == 0) m_done = 1;
        else begin
          m_busy = 1; m_state = start_state & (full - 1); m_stage = end_stage; m_cnt = depth;
          m_tag = "R9";
        end
      end
      if (tbl_we) mtbl[tbl_addr] = tbl_wdata;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 busy", busy, m_busy);
      chk("R7 done", done, m_done);
      chk("R6 bit_valid", bit_valid, m_valid);
      if (m_valid) chk({m_tag, " bit_out"}, bit_out, m_bit);
      if (m_busy) begin
        chk("R6 mem_addr", mem_addr, m_stage);
        chk({m_tag, " cur_state"}, cur_state, m_state);
      end
      nbits += bit_valid;
      ndone += done;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nbad++; nchk++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic run(input int k, input bit md, input int st, input int dp, input int es,
                     input bit coll, input bit restart, input string tag);
    @(negedge clk);
    k_len = 4'(k); mode = md; start_state = 8'(st); depth = 10'(dp); end_stage = 10'(es);
    start = 1; nbits = 0; ndone = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < dp + 4; i++) begin
      if (coll && m_busy) begin
        int ix;
        ix = 2 * m_state + dmem[m_stage & 63][m_state];
        tbl_we = 1; tbl_addr = 9'(ix); tbl_wdata = ~mtbl[ix];  // R5 collision
      end else tbl_we = 0;
      if (restart && i == 2) begin  // R8 start while busy
        start = 1; start_state = 8'hA5; depth = 10'd2; end_stage = 10'd7;
      end else start = 0;
      @(negedge clk);
    end
    tbl_we = 0; start = 0;
    chk({tag, " bits"}, nbits, dp);
    chk({tag, " done pulses"}, ndone, 1);
  endtask

  initial begin
    int s;
    s = 32'h1234567;
    for (int w = 0; w < 64; w++)
      for (int j = 0; j < 8; j++) begin
        s = s ^ (s << 13); s = s ^ (s >>> 17); s = s ^ (s << 5);
        dmem[w][j*32 +: 32] = s;
      end
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 bit_valid", bit_valid, 0);
    rst_n = 1;
    @(negedge clk);
    run(3, 0, 3, 12, 20, 0, 0, "R3");
    run(9, 0, 200, 40, 63, 0, 0, "R2");
    run(5, 0, 255, 15, 30, 0, 0, "R9");
    run(2, 0, 7, 8, 10, 0, 0, "R9");
    run(12, 0, 129, 8, 5, 0, 0, "R9");
    run(7, 1, 50, 20, 40, 0, 0, "R4 zero-table");
    for (int i = 0; i < 512; i++) begin
      tbl_we = 1; tbl_addr = 9'(i); tbl_wdata = ((i * 37) >> 3 ^ i) & 1;
      @(negedge clk);
    end
    tbl_we = 0;
    run(7, 1, 50, 30, 45, 0, 0, "R4");
    run(4, 1, 6, 20, 12, 0, 0, "R4");
    run(9, 1, 77, 25, 60, 1, 0, "R5");
    run(9, 1, 77, 25, 60, 0, 0, "R5 after");
    run(6, 0, 20, 0, 3, 0, 0, "R7");
    run(8, 0, 99, 10, 15, 0, 1, "R8");
    run(8, 1, 1, 1, 0, 0, 0, "R6");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule